// File: doc/BRIEF.md
# Variable-Width Double-Rate Packet Link Transmitter

This block drives one direction of a point-to-point packet link. Upstream logic hands it packets as a stream of 32-bit words with a valid/ready handshake and a last-word marker. The block stores each packet, then sends it over a lane whose active width can be chosen at run time from 2, 4, 8, 16 or 32 bits. When the lane is narrower than a word, each word is split into several beats, least significant slice first. Two beats leave per core clock, one for each clock edge, so a 16-bit lane moves a full word every cycle.

Each beat carries a frame qualifier. The qualifier stays high for every beat of a packet and drops between packets. A companion receiver module rebuilds the words at the far end, reports the end of each frame, and flags any frame that stops partway through a word. The width setting applies only between packets. A new setting made while a packet is on the wire is held back until that packet has gone out.

Top module: `plink_ser_tx`

## Requirements
- R1: `width_sel_i` codes 0,1,2,3,4 select a lane of 2,4,8,16,32 bits. `lane_width_o` reports the active code, which is 3 after reset. Codes 5 to 7 are ignored, and the previous code stays active.
- R2: A word is sent in 32/W beats, beat k carrying bits [k*W+W-1:k*W], least significant beat first. Lane bits at or above W are zero while a beat is framed.
- R3: Each cycle carries a beat pair. `data_rise_o` holds even-numbered beat 2p and `data_fall_o` holds odd-numbered beat 2p+1. At 32 bits only the rising beat is used and `frame_fall_o` stays low.
- R4: The frame outputs are high for exactly the beats of a packet, which is len*max(1,16/W) cycles on the rising side. At least one cycle with both frames low separates two packets.
- R5: A packet holds 1 to 16 words and ends at the word with `last_i` set. A 16th word without `last_i` ends the packet, and the next accepted word opens a new one.
- R6: The packet is stored and then sent. `ready_o` is high while nothing is being sent. When the final word is accepted at edge E, `ready_o` is low after E, the first beat pair appears after edge E+1, and `ready_o` returns once the last pair has been launched.
- R7: A width change requested while a packet is being sent does not affect that packet. It takes effect once the link is idle.
- R8: The receiver outputs each rebuilt word with a one-cycle valid pulse. It raises an end pulse one cycle after the rising-side frame goes low.
- R9: If a frame ends on a beat that does not complete a 32-bit word, the receiver raises an error with that end pulse. Otherwise there is no error.
- R10: During and after reset, both frames are low, both data outputs are zero and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; beat pairs launch once per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_sel_i | input | 3 | Requested lane width code |
| word_i | input | 32 | Packet word |
| valid_i | input | 1 | Word present |
| last_i | input | 1 | Final word of the packet |
| ready_o | output | 1 | Word accepted at this edge when valid |
| lane_width_o | output | 3 | Active lane width code |
| data_rise_o | output | 32 | Beat for the rising edge, low W bits used |
| data_fall_o | output | 32 | Beat for the falling edge, low W bits used |
| frame_rise_o | output | 1 | Rising-edge beat belongs to a packet |
| frame_fall_o | output | 1 | Falling-edge beat belongs to a packet |

## Verification
If the beat-pair index slips, the receiver rebuilds words with shifted or mixed slices, and the word comparison fails within that packet. If the word index or the stored end index is wrong, the frame stays high for the wrong number of cycles. That shows up as a frame-length and word-count mismatch at the end pulse, a single frame after the fault. If the width register changes while a packet is being sent, the beat count breaks at the next word boundary. The receiver then reports a partial-word error or garbled words before the packet closes.

// File: rtl/plink_pkg.sv
package plink_pkg;
  localparam int WORD_W = 32;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    LANE_2  = 3'd0,
    LANE_4  = 3'd1,
    LANE_8  = 3'd2,
    LANE_16 = 3'd3,
    LANE_32 = 3'd4
  } lane_code_e;

  typedef enum logic {ST_IDLE, ST_SEND} tx_state_e;

  function automatic logic code_ok(logic [CODE_W-1:0] c);
    return c <= 3'(LANE_32);
  endfunction

  function automatic logic [5:0] width_of(logic [CODE_W-1:0] c);
    return 6'd2 << c;
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(logic [CODE_W-1:0] c);
    return {WORD_W{1'b1}} >> (6'd32 - width_of(c));
  endfunction

  // beat pairs per word: one pair per cycle
  function automatic logic [3:0] pairs_of(logic [CODE_W-1:0] c);
    return (c >= 3'(LANE_16)) ? 4'd1 : (4'd8 >> c);
  endfunction

  function automatic logic [4:0] beats_of(logic [CODE_W-1:0] c);
    return 5'd16 >> c;
  endfunction
endpackage

// File: rtl/plink_width_reg.sv
module plink_width_reg
  import plink_pkg::*;
#(
  parameter logic [CODE_W-1:0] RESET_CODE = 3'(LANE_16)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              hold_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= RESET_CODE;
    else if (!hold_i && code_ok(req_code_i)) code_o <= req_code_i;
  end

  assert_code_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= 3'(LANE_32));
  assert_hold_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(code_o));
endmodule

// File: rtl/plink_pkt_buf.sv
module plink_pkt_buf
  import plink_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/plink_beat_slicer.sv
module plink_beat_slicer
  import plink_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [2:0]        pair_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] rise_o,
  output logic [WORD_W-1:0] fall_o,
  output logic              fall_en_o
);
  logic [5:0]        w;
  logic [5:0]        sh_r;
  logic [5:0]        sh_f;
  logic [WORD_W-1:0] m;

  always_comb begin
    w         = width_of(code_i);
    m         = lane_mask(code_i);
    sh_r      = {2'b0, pair_i, 1'b0} * w;
    sh_f      = {2'b0, pair_i, 1'b1} * w;
    fall_en_o = (code_i != 3'(LANE_32));
    rise_o    = (word_i >> sh_r) & m;
    fall_o    = fall_en_o ? ((word_i >> sh_f) & m) : '0;
  end
endmodule

// File: rtl/plink_tx_ctl.sv
module plink_tx_ctl
  import plink_pkg::*;
#(
  parameter int MAX_WORDS = 16,
  localparam int IDX_W = $clog2(MAX_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ready_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [2:0]        pair_o,
  output logic              sending_o
);
  tx_state_e        state_q;
  logic [IDX_W-1:0] cnt_q, last_idx_q, widx_q;
  logic [2:0]       pidx_q;
  logic [2:0]       pmax;
  logic             close_pkt;

  assign pmax      = 3'(pairs_of(code_i) - 4'd1);
  assign ready_o   = (state_q == ST_IDLE);
  assign sending_o = (state_q == ST_SEND);
  assign wr_en_o   = ready_o && valid_i;
  assign wr_idx_o  = cnt_q;
  assign rd_idx_o  = widx_q;
  assign pair_o    = pidx_q;
  assign close_pkt = last_i || (cnt_q == IDX_W'(MAX_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      last_idx_q <= '0;
      widx_q     <= '0;
      pidx_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (valid_i) begin
          if (close_pkt) begin
            state_q    <= ST_SEND;
            last_idx_q <= cnt_q;
            cnt_q      <= '0;
            widx_q     <= '0;
            pidx_q     <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (pidx_q == pmax) begin
            pidx_q <= '0;
            if (widx_q == last_idx_q) state_q <= ST_IDLE;
            else widx_q <= widx_q + 1'b1;
          end else begin
            pidx_q <= pidx_q + 1'b1;
          end
        end
      endcase
    end
  end

  assert_word_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND) |-> (widx_q <= last_idx_q));
  assert_pair_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND) |-> (pidx_q <= pmax));
  assert_fill_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND) |-> (cnt_q == '0));
endmodule

// File: rtl/plink_deser_rx.sv
module plink_deser_rx
  import plink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic [WORD_W-1:0] data_rise_i,
  input  logic [WORD_W-1:0] data_fall_i,
  input  logic              frame_rise_i,
  input  logic              frame_fall_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              end_o,
  output logic              err_o
);
  logic [WORD_W-1:0] acc_q, a1, dw, m;
  logic [4:0]        bc_q, b1, nb;
  logic [5:0]        w;
  logic              in_frame_q, done, frame_end;

  always_comb begin
    w    = width_of(code_i);
    m    = lane_mask(code_i);
    nb   = beats_of(code_i);
    a1   = acc_q;
    b1   = bc_q;
    done = 1'b0;
    dw   = '0;
    if (frame_rise_i) begin
      a1 = a1 | ((data_rise_i & m) << ({1'b0, b1} * w));
      b1 = b1 + 5'd1;
      if (b1 == nb) begin
        done = 1'b1; dw = a1; a1 = '0; b1 = '0;
      end
    end
    if (frame_rise_i && frame_fall_i && code_i != 3'(LANE_32)) begin
      a1 = a1 | ((data_fall_i & m) << ({1'b0, b1} * w));
      b1 = b1 + 5'd1;
      if (b1 == nb) begin
        done = 1'b1; dw = a1; a1 = '0; b1 = '0;
      end
    end
  end

  assign frame_end = in_frame_q && !frame_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= '0;
      bc_q         <= '0;
      in_frame_q   <= 1'b0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
      end_o        <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      in_frame_q   <= frame_rise_i;
      word_valid_o <= done;
      end_o        <= frame_end;
      err_o        <= frame_end && (bc_q != '0);
      if (done) word_o <= dw;
      if (frame_rise_i) begin
        acc_q <= a1;
        bc_q  <= b1;
      end else if (in_frame_q) begin
        acc_q <= '0;
        bc_q  <= '0;
      end
    end
  end

  assert_err_at_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> end_o);
  assert_end_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> !word_valid_o);
  assert_beat_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_q < beats_of(code_i) || !frame_rise_i);
endmodule

// File: rtl/plink_ser_tx.sv
module plink_ser_tx
  import plink_pkg::*;
#(
  parameter int                MAX_WORDS  = 16,
  parameter logic [CODE_W-1:0] RESET_CODE = 3'(LANE_16),
  localparam int               IDX_W      = $clog2(MAX_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] width_sel_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              ready_o,
  output logic [CODE_W-1:0] lane_width_o,
  output logic [WORD_W-1:0] data_rise_o,
  output logic [WORD_W-1:0] data_fall_o,
  output logic              frame_rise_o,
  output logic              frame_fall_o
);
  logic              wr_en, sending, fall_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [2:0]        pair;
  logic [WORD_W-1:0] rd_word, rise_beat, fall_beat;

  plink_width_reg #(.RESET_CODE(RESET_CODE)) u_width (
    .clk_i, .rst_ni, .req_code_i(width_sel_i), .hold_i(sending), .code_o(lane_width_o)
  );

  plink_tx_ctl #(.MAX_WORDS(MAX_WORDS)) u_ctl (
    .clk_i, .rst_ni, .valid_i, .last_i, .code_i(lane_width_o), .ready_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .rd_idx_o(rd_idx), .pair_o(pair),
    .sending_o(sending)
  );

  plink_pkt_buf #(.DEPTH(MAX_WORDS)) u_buf (
    .clk_i, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(word_i),
    .rd_idx_i(rd_idx), .rd_data_o(rd_word)
  );

  plink_beat_slicer u_slice (
    .word_i(rd_word), .pair_i(pair), .code_i(lane_width_o),
    .rise_o(rise_beat), .fall_o(fall_beat), .fall_en_o(fall_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_rise_o  <= '0;
      data_fall_o  <= '0;
      frame_rise_o <= 1'b0;
      frame_fall_o <= 1'b0;
    end else if (sending) begin
      data_rise_o  <= rise_beat;
      data_fall_o  <= fall_beat;
      frame_rise_o <= 1'b1;
      frame_fall_o <= fall_en;
    end else begin
      data_rise_o  <= '0;
      data_fall_o  <= '0;
      frame_rise_o <= 1'b0;
      frame_fall_o <= 1'b0;
    end
  end

  assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((data_rise_o | data_fall_o) & ~lane_mask(lane_width_o)) == '0);
  assert_fall_pairs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_fall_o |-> frame_rise_o);
  assert_full_width_rise_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_width_o == 3'(LANE_32)) |-> !frame_fall_o);
  assert_start_after_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_rise_o) |-> $past(!ready_o));
endmodule

// File: tb/sim_plink_ser_tx.sv
module sim_plink_ser_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  width_sel_i = 3'd3;
  logic [31:0] word_i = '0;
  logic        valid_i = 1'b0;
  logic        last_i = 1'b0;
  logic        ready_o, frame_rise_o, frame_fall_o;
  logic [2:0]  lane_width_o;
  logic [31:0] data_rise_o, data_fall_o;

  logic        inj = 1'b0, inj_fr = 1'b0, inj_ff = 1'b0;
  logic [2:0]  inj_code = 3'd2;
  logic [31:0] inj_rise = '0, inj_fall = '0;
  logic        d_fr, d_ff;
  logic [2:0]  d_code;
  logic [31:0] d_rise, d_fall, rx_word;
  logic        rx_valid, rx_end, rx_err;

  int checks = 0, fails = 0;
  int fr_cnt, ff_cnt, hi_bad, rx_n, end_cnt, err_cnt, first_end_n, fall_cyc, end_cyc;
  int cyc = 0;
  logic prev_fr = 1'b0;
  logic [31:0] rx_q [0:63];
  logic [2:0] cur_eff = 3'd3;

  always #5 clk_i = ~clk_i;

  plink_ser_tx u0 (.*);

  assign d_fr   = inj ? inj_fr   : frame_rise_o;
  assign d_ff   = inj ? inj_ff   : frame_fall_o;
  assign d_code = inj ? inj_code : lane_width_o;
  assign d_rise = inj ? inj_rise : data_rise_o;
  assign d_fall = inj ? inj_fall : data_fall_o;

  plink_deser_rx u_rx (
    .clk_i, .rst_ni, .code_i(d_code), .data_rise_i(d_rise), .data_fall_i(d_fall),
    .frame_rise_i(d_fr), .frame_fall_i(d_ff), .word_o(rx_word),
    .word_valid_o(rx_valid), .end_o(rx_end), .err_o(rx_err)
  );

  function automatic logic [31:0] exp_mask(logic [2:0] c);
    return 32'hFFFF_FFFF >> (32 - (2 << c));
  endfunction
  function automatic int exp_pairs(logic [2:0] c);
    return (c >= 3) ? 1 : (8 >> c);
  endfunction
  function automatic logic [31:0] gen_word(logic [7:0] s, int i);
    return {s, 8'(i), 16'h5A3C} ^ (32'h9E37_79B9 * 32'(i + 1)) ^ (32'h85EB_CA6B * 32'(s));
  endfunction

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    prev_fr <= d_fr;
    if (prev_fr && !d_fr) fall_cyc = cyc;
    if (d_fr) fr_cnt++;
    if (d_ff) ff_cnt++;
    if (d_fr && ((d_rise | (d_ff ? d_fall : 32'h0)) & ~exp_mask(d_code)) != 0) hi_bad++;
    if (rx_valid) begin
      if (rx_n < 64) rx_q[rx_n] = rx_word;
      rx_n++;
    end
    if (rx_end) begin
      if (end_cnt == 0) first_end_n = rx_n;
      end_cnt++;
      end_cyc = cyc;
    end
    if (rx_err) err_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk_i); #1;
    fr_cnt = 0; ff_cnt = 0; hi_bad = 0; rx_n = 0; end_cnt = 0; err_cnt = 0;
    first_end_n = 0; fall_cyc = 0; end_cyc = 0;
  endtask

  task automatic run_pkt(input logic [2:0] code, input int len, input logic [7:0] seed,
                         input bit mid_sw, input logic [2:0] sw_code);
    logic [2:0] eff;
    int mism, exp_ends;
    eff = (code <= 3'd4) ? code : cur_eff;
    exp_ends = (len > 16) ? 2 : 1;
    clear_mon();
    @(negedge clk_i) width_sel_i = code;
    for (int i = 0; i < len; i++) begin
      while (!ready_o) @(negedge clk_i);
      word_i = gen_word(seed, i); valid_i = 1'b1; last_i = (i == len - 1);
      @(negedge clk_i);
    end
    valid_i = 1'b0; last_i = 1'b0;
    if (mid_sw) begin
      width_sel_i = sw_code;
      repeat (3) @(negedge clk_i);
      chk("R7 width held while sending", 32'(lane_width_o), 32'(eff));
    end
    while (end_cnt < exp_ends) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    mism = 0;
    for (int i = 0; i < rx_n && i < 64; i++) if (rx_q[i] !== gen_word(seed, i)) mism++;
    chk("R5 word count", 32'(rx_n), 32'(len));
    chk("R2 word data mismatches", 32'(mism), 0);
    chk("R8 end pulses", 32'(end_cnt), 32'(exp_ends));
    if (len > 16) chk("R5 forced end after 16", 32'(first_end_n), 32'd16);
    chk("R4 rising frame beats", 32'(fr_cnt), 32'(len * exp_pairs(eff)));
    chk("R3 falling frame beats", 32'(ff_cnt), (eff == 3'd4) ? 0 : 32'(len * exp_pairs(eff)));
    chk("R2 upper lane bits", 32'(hi_bad), 0);
    chk("R9 no error on whole words", 32'(err_cnt), 0);
    if (mid_sw && sw_code <= 3'd4) eff = sw_code;
    chk("R1 active width code", 32'(lane_width_o), 32'(eff));
    cur_eff = eff;
  endtask

  localparam logic [15:0] VEC [0:9] = '{
    {3'd0, 5'd1, 8'h11}, {3'd1, 5'd3, 8'h22}, {3'd2, 5'd4, 8'h33},
    {3'd3, 5'd16, 8'h44}, {3'd4, 5'd2, 8'h55}, {3'd4, 5'd16, 8'h66},
    {3'd0, 5'd5, 8'h77}, {3'd3, 5'd1, 8'h88}, {3'd2, 5'd7, 8'h99},
    {3'd1, 5'd16, 8'hAA}
  };

  initial begin
    logic [31:0] w0;
    repeat (3) @(negedge clk_i);
    chk("R10 frame in reset", {30'd0, frame_rise_o, frame_fall_o}, 0);
    chk("R10 ready in reset", 32'(ready_o), 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R10 data idle", data_rise_o | data_fall_o, 0);
    chk("R10 reset width code", 32'(lane_width_o), 3);
    chk("R10 ready idle", 32'(ready_o), 1);

    for (int v = 0; v < 10; v++)
      run_pkt(VEC[v][15:13], int'(VEC[v][12:8]), VEC[v][7:0], 1'b0, 3'd0);

    // R6 / R3 cycle timing, 16-bit lane, single word
    clear_mon();
    w0 = 32'hC0DE_4B1D;
    @(negedge clk_i) width_sel_i = 3'd3; word_i = w0; valid_i = 1'b1; last_i = 1'b1;
    @(negedge clk_i) valid_i = 1'b0; last_i = 1'b0;
    chk("R6 ready low after accept", 32'(ready_o), 0);
    chk("R6 no beat in accept cycle", 32'(frame_rise_o), 0);
    @(negedge clk_i);
    chk("R6 first pair one edge later", {30'd0, frame_rise_o, frame_fall_o}, 3);
    chk("R3 rising beat low half", data_rise_o, {16'h0, w0[15:0]});
    chk("R3 falling beat high half", data_fall_o, {16'h0, w0[31:16]});
    @(negedge clk_i);
    chk("R4 frame drops after packet", 32'(frame_rise_o), 0);
    chk("R6 ready back after last pair", 32'(ready_o), 1);
    while (end_cnt == 0) @(negedge clk_i);
    chk("R8 end one cycle after frame drop", 32'(end_cyc), 32'(fall_cyc + 1));
    chk("R8 rebuilt word", rx_q[0], w0);
    cur_eff = 3'd3;

    // R1 reserved code ignored
    run_pkt(3'd6, 4, 8'hB1, 1'b0, 3'd0);
    // R5 overflow into a second packet
    run_pkt(3'd2, 20, 8'hC2, 1'b0, 3'd0);
    // R7 change requested mid-packet
    run_pkt(3'd0, 16, 8'hD3, 1'b1, 3'd3);

    // R9 receiver partial-word detection (8-bit lane, 4 beats per word)
    clear_mon();
    @(negedge clk_i) inj = 1'b1; inj_code = 3'd2;
    inj_fr = 1'b1; inj_ff = 1'b1; inj_rise = 32'h11; inj_fall = 32'h22;
    @(negedge clk_i) inj_fr = 1'b0; inj_ff = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R9 error on two of four beats", 32'(err_cnt), 1);
    chk("R9 no word from partial frame", 32'(rx_n), 0);
    clear_mon();
    @(negedge clk_i) inj_fr = 1'b1; inj_ff = 1'b1; inj_rise = 32'h11; inj_fall = 32'h22;
    @(negedge clk_i) inj_ff = 1'b0; inj_rise = 32'h33;
    @(negedge clk_i) inj_fr = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R9 error on rise-only tail", 32'(err_cnt), 1);
    clear_mon();
    @(negedge clk_i) inj_fr = 1'b1; inj_ff = 1'b1; inj_rise = 32'h11; inj_fall = 32'h22;
    @(negedge clk_i) inj_rise = 32'h33; inj_fall = 32'h44;
    @(negedge clk_i) inj_fr = 1'b0; inj_ff = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R9 no error on whole word", 32'(err_cnt), 0);
    chk("R8 word rebuilt LS beat first", rx_q[0], 32'h4433_2211);
    chk("R8 single end pulse", 32'(end_cnt), 1);
    inj = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule